// File: doc/BRIEF.md
# SPI Multi-Target Chip-Select Controller

This block owns the chip-select pins of an SPI master that talks to as many as four targets. It takes its configuration as plain field values (a target index, a manual-mode enable, a manual level and a polarity flag) from a register decoder outside the block. It also takes a burst request and a burst-end pulse from the transfer engine. One line at a time is the selected line. Every other line rests at the idle level that the polarity flag implies: high when the flag marks the lines active-low, low when it does not.

In automatic mode the selected line is framed around each burst. The line goes active as soon as a request is taken. The block then waits a configurable lead time of one SPI half-period, counted in system clocks, and pulses a start strobe to the engine. The line is released on the clock after the engine reports that the last bit has finished. The target index is captured when a burst begins and is held until the burst ends.

In manual mode the selected pin copies the manual level bit directly and ignores framing. The request and start handshake still runs, so the engine is not stalled. The pins are also returned on a second output for the transfer engine's own use. The reset is asynchronous and active-low, and it is released through a two-flop synchronizer.

Top module: `cs_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after the synchronized release, all four `cs_pin` bits are 1 (the deasserted level for active-low) and `burst_go` is 0.
- R2: Bit n of `cs_pin` is the line for target index n (`tgt_sel` value 0 to 3); only that bit may leave the idle level.
- R3: In automatic mode, a `burst_req` accepted while idle drives the selected line to its active level on the next clock edge. `burst_go` is then high for exactly one cycle, `LEAD_CYC` cycles after that edge.
- R4: In automatic mode, a `burst_end` seen while a burst is running returns the selected line to the idle level on the next clock edge.
- R5: With `man_en` = 1, the selected pin equals `man_lvl` one clock later, whatever the polarity and the framing state.
- R6: With `act_low` = 1, unselected and idle lines are 1 and an active line is 0. With `act_low` = 0, unselected and idle lines are 0 and an active line is 1.
- R7: A change of `tgt_sel` during the lead time or during a burst does not move the framing to another line until the burst has ended.
- R8: A `burst_req` that arrives while a lead or a burst is in progress, including the cycle of `burst_end`, is ignored: no new frame and no extra `burst_go`.
- R9: In manual mode the request/start handshake still produces `burst_go` at the same lead time as in automatic mode.
- R10: `cs_seen` carries the same value as `cs_pin` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_sel | input | 2 | Index of the selected target line |
| man_en | input | 1 | 1 = selected pin follows `man_lvl` |
| man_lvl | input | 1 | Pin level applied in manual mode |
| act_low | input | 1 | 1 = lines assert low and idle high |
| burst_req | input | 1 | Engine requests framing of a new burst |
| burst_end | input | 1 | Engine reports that the last bit is done |
| burst_go | output | 1 | One-cycle strobe: lead time elapsed, engine may shift |
| cs_pin | output | 4 | Chip-select pins |
| cs_seen | output | 4 | Chip-select levels returned to the engine |

## Verification
Two things can land in the same cycle: the end of one burst and a request for the next. The request must lose, because the block is still in its burst phase on that edge. The bench raises `burst_end` and `burst_req` together and then checks that the line returns to idle and that no new lead or `burst_go` follows. A second collision is a target change in the same cycle as an accepted request; that check expects the new index to be the one framed. A third is a target change during a burst; that check expects the pins not to move. A behavioural model, written with integers, runs next to the design and is compared on every falling edge.

// File: rtl/cs_ctrl_pkg.sv
package cs_ctrl_pkg;
  // framing phase of the selected line
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_BURST = 2'd2
  } cs_phase_e;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_q = s2_q;
endmodule

// File: rtl/cs_frame_fsm.sv
module cs_frame_fsm
  import cs_ctrl_pkg::*;
#(
  parameter int LEAD_CYC = 4,
  parameter int TGT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             burst_req,
  input  logic             burst_end,
  input  logic [TGT_W-1:0] tgt_sel,
  output cs_phase_e        phase_q,
  output cs_phase_e        phase_d,
  output logic [TGT_W-1:0] tgt_q,
  output logic [TGT_W-1:0] tgt_d,
  output logic             go_q
);
  localparam int CNT_W = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEAD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             go_d;
  logic             lead_last;
  logic             tgt_en;

  assign lead_last = (cnt_q == CNT_LAST);
  // target index may only be refreshed between bursts
  assign tgt_en    = (phase_q == PH_IDLE);
  assign tgt_d     = tgt_en ? tgt_sel : tgt_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    go_d    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (burst_req) begin
          phase_d = PH_LEAD;
          cnt_d   = '0;
        end
      end
      PH_LEAD: begin
        if (lead_last) begin
          phase_d = PH_BURST;
          go_d    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_BURST: begin
        if (burst_end) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      go_q    <= 1'b0;
      tgt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      go_q    <= go_d;
      if (tgt_en) tgt_q <= tgt_sel;
    end
  end
endmodule

// File: rtl/cs_line_drv.sv
module cs_line_drv #(
  parameter int IDX   = 0,
  parameter int TGT_W = 2
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic [TGT_W-1:0] tgt_d,
  input  logic             frame_on_d,
  input  logic             man_en,
  input  logic             man_lvl,
  input  logic             act_low,
  output logic             pin_q
);
  logic sel;
  logic pin_d;

  assign sel = (tgt_d == TGT_W'(IDX));

  always_comb begin
    if (!sel)            pin_d = act_low;          // idle level
    else if (man_en)     pin_d = man_lvl;          // raw override
    else if (frame_on_d) pin_d = ~act_low;         // framed, active
    else                 pin_d = act_low;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) pin_q <= 1'b1;
    else        pin_q <= pin_d;
  end
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_ctrl_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int LEAD_CYC = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [((NUM_CS > 1) ? $clog2(NUM_CS) : 1)-1:0] tgt_sel,
  input  logic                                       man_en,
  input  logic                                       man_lvl,
  input  logic                                       act_low,
  input  logic                                       burst_req,
  input  logic                                       burst_end,
  output logic                                       burst_go,
  output logic [NUM_CS-1:0]                          cs_pin,
  output logic [NUM_CS-1:0]                          cs_seen
);
  localparam int TGT_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic             rst_q;
  cs_phase_e        phase_q;
  cs_phase_e        phase_d;
  logic [TGT_W-1:0] tgt_q;
  logic [TGT_W-1:0] tgt_d;
  logic             frame_on_d;
  logic [NUM_CS-1:0] pin_w;

  cs_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  cs_frame_fsm #(
    .LEAD_CYC (LEAD_CYC),
    .TGT_W    (TGT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_q     (rst_q),
    .burst_req (burst_req),
    .burst_end (burst_end),
    .tgt_sel   (tgt_sel),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .tgt_q     (tgt_q),
    .tgt_d     (tgt_d),
    .go_q      (burst_go)
  );

  assign frame_on_d = (phase_d != PH_IDLE);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    cs_line_drv #(
      .IDX   (g),
      .TGT_W (TGT_W)
    ) u_line (
      .clk        (clk),
      .rst_q      (rst_q),
      .tgt_d      (tgt_d),
      .frame_on_d (frame_on_d),
      .man_en     (man_en),
      .man_lvl    (man_lvl),
      .act_low    (act_low),
      .pin_q      (pin_w[g])
    );
  end

  assign cs_pin  = pin_w;
  assign cs_seen = pin_w;
endmodule

// File: rtl/cs_ctrl_chk.sv
module cs_ctrl_chk
  import cs_ctrl_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int TGT_W  = 2
) (
  input logic              clk,
  input logic              rst_q,
  input cs_phase_e         phase,
  input logic [TGT_W-1:0]  tgt_lat,
  input logic [NUM_CS-1:0] cs_pin,
  input logic              burst_go,
  input logic              burst_req,
  input logic              burst_end,
  input logic              man_en,
  input logic              man_lvl,
  input logic              act_low
);
  logic              ok_q;
  logic              al_q;
  logic [NUM_CS-1:0] sel_mask;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ok_q <= 1'b0;
      al_q <= 1'b1;
    end else begin
      ok_q <= 1'b1;
      al_q <= act_low;
    end
  end

  assign sel_mask = NUM_CS'(1) << tgt_lat;

  // R7
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_q || !ok_q)
    ($past(phase) != PH_IDLE) |-> $stable(tgt_lat));

  // R5
  man_lvl_chk: assert property (@(posedge clk) disable iff (!rst_q || !ok_q)
    $past(man_en) |-> (cs_pin[tgt_lat] == $past(man_lvl)));

  // R6
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_q || !ok_q)
    (((cs_pin ^ {NUM_CS{al_q}}) & ~sel_mask) == '0));

  // R3
  go_after_lead_chk: assert property (@(posedge clk) disable iff (!rst_q || !ok_q)
    burst_go |-> (phase == PH_BURST && $past(phase) == PH_LEAD));

  // R3
  auto_active_chk: assert property (@(posedge clk) disable iff (!rst_q || !ok_q)
    (!$past(man_en) && phase != PH_IDLE) |-> (cs_pin[tgt_lat] == ~al_q));

  // R4
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_q || !ok_q)
    (phase == PH_BURST && burst_end) |=> (phase == PH_IDLE));

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_q || !ok_q)
    (phase == PH_LEAD && burst_req) |=> (phase != PH_IDLE));
endmodule

bind cs_ctrl cs_ctrl_chk #(
  .NUM_CS (NUM_CS),
  .TGT_W  (TGT_W)
) chk_i (
  .clk       (clk),
  .rst_q     (rst_q),
  .phase     (phase_q),
  .tgt_lat   (tgt_q),
  .cs_pin    (cs_pin),
  .burst_go  (burst_go),
  .burst_req (burst_req),
  .burst_end (burst_end),
  .man_en    (man_en),
  .man_lvl   (man_lvl),
  .act_low   (act_low)
);

// File: tb/cs_ctrl_tb_top.sv
module cs_ctrl_tb_top;
  localparam int LEAD = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] tgt_sel;
  logic       man_en, man_lvl, act_low, burst_req, burst_end;
  logic       burst_go;
  logic [3:0] cs_pin, cs_seen;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cs_ctrl #(.NUM_CS(4), .LEAD_CYC(LEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel), .man_en(man_en),
    .man_lvl(man_lvl), .act_low(act_low), .burst_req(burst_req),
    .burst_end(burst_end), .burst_go(burst_go), .cs_pin(cs_pin),
    .cs_seen(cs_seen)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 lead, 2 burst
  int         rel, mph, nph, mlc, mt;
  logic [3:0] mpin;
  logic       mgo, mman;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; mph = 0; mlc = 0; mt = 0; mpin = 4'hF; mgo = 0; mman = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      nph = mph;
      mgo = 0;
      if (mph == 0) begin
        if (burst_req) begin nph = 1; mlc = 0; end
      end else if (mph == 1) begin
        if (mlc == LEAD - 1) begin nph = 2; mgo = 1; end
        else mlc++;
      end else begin
        if (burst_end) nph = 0;
      end
      if (mph == 0) mt = int'(tgt_sel);
      mph  = nph;
      mman = man_en;
      for (int i = 0; i < 4; i++) begin
        if (i != mt)     mpin[i] = act_low;
        else if (man_en) mpin[i] = man_lvl;
        else if (mph != 0) mpin[i] = ~act_low;
        else             mpin[i] = act_low;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    chk(cs_pin === mpin, mman ? "R5 model pins" : "R6 model pins", cs_pin, mpin);
    chk(cs_seen === cs_pin, "R10 seen copy", cs_seen, cs_pin);
    chk(burst_go === mgo, "R3 model go", burst_go, mgo);
  end

  task automatic step(); @(negedge clk); endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; tgt_sel = 0; man_en = 0; man_lvl = 0; act_low = 1;
    burst_req = 0; burst_end = 0;
    repeat (3) step();
    chk(cs_pin == 4'hF, "R1 pins in reset", cs_pin, 4'hF);
    chk(burst_go == 0, "R1 go in reset", burst_go, 0);
    rst_n = 1;
    repeat (3) step();
    chk(cs_pin == 4'hF, "R1 pins after release", cs_pin, 4'hF);

    // automatic burst on target 2, active-low
    tgt_sel = 2; burst_req = 1;
    step(); burst_req = 0;
    chk(cs_pin == 4'b1011, "R2 line 2 active", cs_pin, 4'b1011);
    for (int i = 0; i < LEAD - 1; i++) begin
      step(); chk(burst_go == 0, "R3 go early", burst_go, 0);
    end
    step(); chk(burst_go == 1, "R3 go at lead", burst_go, 1);
    tgt_sel = 1; burst_req = 1;
    step(); burst_req = 0;
    chk(burst_go == 0, "R3 go one cycle", burst_go, 0);
    chk(cs_pin == 4'b1011, "R7 target held", cs_pin, 4'b1011);
    repeat (3) step();
    chk(cs_pin == 4'b1011, "R7 target still held", cs_pin, 4'b1011);
    // end and new request in the same cycle
    burst_end = 1; burst_req = 1;
    step(); burst_end = 0; burst_req = 0;
    chk(cs_pin == 4'hF, "R4 released", cs_pin, 4'hF);
    repeat (LEAD + 2) begin
      step();
      chk(cs_pin == 4'hF, "R8 no new frame", cs_pin, 4'hF);
      chk(burst_go == 0, "R8 no go", burst_go, 0);
    end

    // active-high polarity, target 3
    act_low = 0;
    step(); chk(cs_pin == 4'h0, "R6 idle low", cs_pin, 4'h0);
    tgt_sel = 3; burst_req = 1;
    step(); burst_req = 0;
    chk(cs_pin == 4'b1000, "R2 line 3 active high", cs_pin, 4'b1000);
    repeat (LEAD) step();
    burst_end = 1;
    step(); burst_end = 0;
    chk(cs_pin == 4'h0, "R4 released low", cs_pin, 4'h0);

    // manual mode
    act_low = 1; man_en = 1; man_lvl = 0; tgt_sel = 0;
    step(); step();
    chk(cs_pin == 4'b1110, "R5 manual low", cs_pin, 4'b1110);
    act_low = 0; man_lvl = 1;
    step(); chk(cs_pin == 4'b0001, "R5 manual high", cs_pin, 4'b0001);
    man_lvl = 0; burst_req = 1;
    step(); burst_req = 0;
    chk(cs_pin == 4'b0000, "R5 framing bypassed", cs_pin, 4'b0000);
    for (int i = 0; i < LEAD - 1; i++) step();
    step(); chk(burst_go == 1, "R9 go in manual", burst_go, 1);
    act_low = 1; man_en = 0;
    step(); chk(cs_pin == 4'b1110, "R3 auto resumes active", cs_pin, 4'b1110);
    burst_end = 1;
    step(); burst_end = 0;
    chk(cs_pin == 4'hF, "R4 release after manual", cs_pin, 4'hF);

    repeat (4) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule